// File: doc/BRIEF.md
# Burst ADC Serial Frame Receiver

This block receives the serial output of a multichannel sigma-delta converter that drives its own serial clock. Before each burst the converter pulses a frame-start line; the burst then follows as one unbroken bit stream that carries every channel sample back to back. The block brings the serial clock, data and frame-start lines into the system clock domain and detects rising serial-clock edges there, which requires the system clock to run at least four times faster than the serial clock. It samples the data line at each such edge, cuts the stream into channel words, tags each word with its position in the burst, and queues it in a small FIFO.

Words leave through a valid/ready stream. An entry is presented with `out_valid` high and stays unchanged until the consumer takes it by holding `out_ready` high in the same cycle. The consumer may stall for as long as it likes. While it stalls, new words fill the FIFO, and once the FIFO is full further words are dropped and counted as an overrun. A receive-timeout interrupt marks the end of a burst: it rises when data is waiting and the serial clock has been quiet for more than a set number of bit periods. Three sticky error flags record malformed bursts and overruns. A single clear strobe resets all three flags.

Top module: `burst_adc_rx`

## Requirements
- R1: Each burst is taken as NUM_CH words of WORD_W bits (defaults 6 and 16), most significant bit first, sampled at serial-clock rising edges. Word k of a burst leaves with `out_chan` = k, counting from 0.
- R2: A rising edge on `fstart_i` resets the bit count and the channel index to zero. Serial-clock edges that arrive after reset but before the first frame start produce no words.
- R3: The output is a FIFO of FIFO_DEPTH entries (default 4) that keeps words in order. A presented entry keeps `out_valid`, `out_data` and `out_chan` steady until the cycle in which `out_ready` is high.
- R4: A word completed while the FIFO holds FIFO_DEPTH entries is dropped, and `err_ovr` is set and stays set.
- R5: If a frame start arrives after 1 to 95 bits of the current burst, `err_short` is set and stays set. The unfinished word is discarded, and the next burst starts at channel 0.
- R6: Serial-clock edges beyond the 96th after a frame start are ignored and produce no words, and `err_long` is set and stays set.
- R7: `irq_timeout` is high while the FIFO is not empty and more than 32 bit periods have passed since the last serial-clock rising edge. A bit period is `bit_period_i` system clocks, and a value of 0 counts as 1. The interrupt drops once the FIFO empties or a new edge arrives.
- R8: A one-cycle pulse on `clr_i` clears all three error flags. An error that occurs in the same cycle as the clear stays set.
- R9: After reset `out_valid`, `irq_timeout` and all three error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the converter, idles low |
| sdata_i | input | 1 | Serial data from the converter |
| fstart_i | input | 1 | Frame-start pulse before each burst |
| bit_period_i | input | BITP_W | Bit period in system clocks, used by the timeout |
| clr_i | input | 1 | Clear strobe for the error flags |
| out_valid | output | 1 | An entry is presented |
| out_ready | input | 1 | The consumer takes the presented entry |
| out_data | output | WORD_W | Channel word |
| out_chan | output | CH_W | Channel index of the word |
| irq_timeout | output | 1 | Receive-timeout interrupt |
| err_short | output | 1 | Sticky flag: burst cut short by a frame start |
| err_long | output | 1 | Sticky flag: burst carried too many bits |
| err_ovr | output | 1 | Sticky flag: word dropped at a full FIFO |

## Verification
A bit counter that is off by even one position gives a wrong word or channel tag. This shows on the output stream within one word time of the fault: shifted data, channel tags that skip or repeat, or a word too many or too few per burst. A wrong burst-length count instead shows as a spurious or missing short or overlength flag at the next frame start or at the 97th edge. Faults in the FIFO occupancy show as dropped, duplicated or reordered words, or as an overrun flag that is wrong, once the consumer stalls for four words. Faults in the idle counter move the interrupt edge by whole bit periods. The bench observes this against windows at 25 and 40 periods.

// File: rtl/burst_rx_pkg.sv
package burst_rx_pkg;
  // One-cycle error events raised by the deserialiser and the FIFO.
  typedef struct packed {
    logic cut_short;
    logic too_long;
    logic dropped;
  } rx_evt_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rx_deser.sv
module rx_deser #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned NUM_CH = 6,
  localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned TOTAL  = WORD_W * NUM_CH,
  localparam int unsigned CNT_W  = $clog2(TOTAL + 1),
  localparam int unsigned POS_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_rise,
  input  logic              bit_rise,
  input  logic              bit_val,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [CH_W-1:0]   word_chan,
  output logic              short_evt,
  output logic              long_evt
);
  logic              armed;
  logic [CNT_W-1:0]  bit_cnt;
  logic [POS_W-1:0]  pos;
  logic [CH_W-1:0]   chan;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] next_word;

  assign next_word = {shreg[WORD_W-2:0], bit_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      bit_cnt    <= '0;
      pos        <= '0;
      chan       <= '0;
      shreg      <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_chan  <= '0;
      short_evt  <= 1'b0;
      long_evt   <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      short_evt  <= 1'b0;
      long_evt   <= 1'b0;
      if (frame_rise) begin
        if (armed && bit_cnt != '0 && bit_cnt != CNT_W'(TOTAL))
          short_evt <= 1'b1;
        armed   <= 1'b1;
        bit_cnt <= '0;
        pos     <= '0;
        chan    <= '0;
      end else if (bit_rise && armed) begin
        if (bit_cnt == CNT_W'(TOTAL)) begin
          long_evt <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          shreg   <= next_word;
          if (pos == POS_W'(WORD_W - 1)) begin
            pos        <= '0;
            word_valid <= 1'b1;
            word_data  <= next_word;
            word_chan  <= chan;
            chan       <= chan + 1'b1;
          end else begin
            pos <= pos + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int unsigned DW    = 19,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          drop_evt,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [DW-1:0] pop_data
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             full, do_push, do_pop;

  assign full      = (count == CNT_W'(DEPTH));
  assign pop_valid = (count != '0);
  assign pop_data  = mem[rd_ptr];
  assign do_push   = push && !full;
  assign do_pop    = pop_valid && pop_ready;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      drop_evt <= 1'b0;
    end else begin
      drop_evt <= push && full;
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rx_timeout.sv
module rx_timeout #(
  parameter int unsigned BITP_W     = 12,
  parameter int unsigned TO_PERIODS = 32,
  localparam int unsigned PER_W     = $clog2(TO_PERIODS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [BITP_W-1:0] period,
  input  logic              pending,
  output logic              irq
);
  logic [BITP_W-1:0] sub;
  logic [PER_W-1:0]  periods;
  logic              expired;

  assign expired = (periods > PER_W'(TO_PERIODS));
  assign irq     = pending && expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub     <= '0;
      periods <= '0;
    end else if (restart) begin
      sub     <= '0;
      periods <= '0;
    end else if (sub + 1'b1 >= period) begin
      sub <= '0;
      if (!expired) periods <= periods + 1'b1;
    end else begin
      sub <= sub + 1'b1;
    end
  end
endmodule

// File: rtl/burst_adc_rx.sv
module burst_adc_rx
  import burst_rx_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned NUM_CH     = 6,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned BITP_W     = 12,
  parameter int unsigned TO_PERIODS = 32,
  localparam int unsigned CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              fstart_i,
  input  logic [BITP_W-1:0] bit_period_i,
  input  logic              clr_i,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [CH_W-1:0]   out_chan,
  output logic              irq_timeout,
  output logic              err_short,
  output logic              err_long,
  output logic              err_ovr
);
  logic [2:0]        synced;
  logic              sclk_s, sdata_s, fs_s, sclk_d, fs_d;
  logic              sclk_rise, fs_rise;
  logic              w_valid;
  logic [WORD_W-1:0] w_data;
  logic [CH_W-1:0]   w_chan;
  rx_evt_t           evt;

  rx_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({fstart_i, sdata_i, sclk_i}), .q(synced)
  );
  assign {fs_s, sdata_s, sclk_s} = synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      fs_d   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      fs_d   <= fs_s;
    end
  end
  assign sclk_rise = sclk_s && !sclk_d;
  assign fs_rise   = fs_s && !fs_d;

  rx_deser #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_deser (
    .clk(clk), .rst_n(rst_n),
    .frame_rise(fs_rise), .bit_rise(sclk_rise), .bit_val(sdata_s),
    .word_valid(w_valid), .word_data(w_data), .word_chan(w_chan),
    .short_evt(evt.cut_short), .long_evt(evt.too_long)
  );

  rx_fifo #(.DW(WORD_W + CH_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(w_valid), .push_data({w_chan, w_data}), .drop_evt(evt.dropped),
    .pop_valid(out_valid), .pop_ready(out_ready), .pop_data({out_chan, out_data})
  );

  rx_timeout #(.BITP_W(BITP_W), .TO_PERIODS(TO_PERIODS)) u_to (
    .clk(clk), .rst_n(rst_n), .restart(sclk_rise),
    .period(bit_period_i), .pending(out_valid), .irq(irq_timeout)
  );

  // Sticky flags: a new event wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_short <= 1'b0;
      err_long  <= 1'b0;
      err_ovr   <= 1'b0;
    end else begin
      err_short <= evt.cut_short || (err_short && !clr_i);
      err_long  <= evt.too_long  || (err_long  && !clr_i);
      err_ovr   <= evt.dropped   || (err_ovr   && !clr_i);
    end
  end
endmodule

// File: rtl/burst_adc_rx_chk.sv
module burst_adc_rx_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic [CH_W-1:0]   out_chan,
  input logic              irq_timeout,
  input logic              err_short,
  input logic              err_long,
  input logic              err_ovr,
  input logic              sclk_rise
);
  // R3: a stalled entry holds steady
  a_r3_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan));

  // R1: channel tags stay inside the burst
  a_r1_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_chan < CH_W'(NUM_CH));

  // R4: overrun flag is sticky until cleared
  a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovr && !clr_i |=> err_ovr);

  // R5: short-frame flag is sticky until cleared
  a_r5_short_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_short && !clr_i |=> err_short);

  // R6: overlength flag is sticky until cleared
  a_r6_long_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_long && !clr_i |=> err_long);

  // R7: interrupt only with data waiting
  a_r7_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    irq_timeout |-> out_valid);

  // R7: a serial-clock edge withdraws the interrupt
  a_r7_edge_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !irq_timeout);
endmodule

bind burst_adc_rx burst_adc_rx_chk #(.WORD_W(WORD_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_chan(out_chan),
  .irq_timeout(irq_timeout), .err_short(err_short), .err_long(err_long), .err_ovr(err_ovr),
  .sclk_rise(sclk_rise)
);

// File: tb/tb_burst_adc_rx.sv
module tb_burst_adc_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_i = 1'b0, sdata_i = 1'b0, fstart_i = 1'b0;
  logic [11:0] bit_period_i = 12'd10;
  logic        clr_i = 1'b0, out_ready = 1'b0;
  logic        out_valid, irq_timeout, err_short, err_long, err_ovr;
  logic [15:0] out_data;
  logic [2:0]  out_chan;

  int checks = 0, fails = 0;
  logic [15:0] rx_data [64];
  int          rx_chan [64];
  int          rx_n = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  burst_adc_rx dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdata_i(sdata_i), .fstart_i(fstart_i),
    .bit_period_i(bit_period_i), .clr_i(clr_i), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_chan(out_chan), .irq_timeout(irq_timeout),
    .err_short(err_short), .err_long(err_long), .err_ovr(err_ovr)
  );

  // Record every transfer; sampled between edges.
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready && rx_n < 64) begin
      rx_data[rx_n] = out_data;
      rx_chan[rx_n] = int'(out_chan);
      rx_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] wd(input int seed, input int ch);
    return 16'(seed * 4099 + ch * 771 + 23100) ^ 16'(ch << 12);
  endfunction

  task automatic send_bit(input logic b);
    sdata_i = b;
    wclk(5);
    sclk_i = 1'b1;
    wclk(5);
    sclk_i = 1'b0;
  endtask

  // Frame start followed by nbits (beyond 96 the extra bits are ones).
  task automatic send_burst(input int seed, input int nbits, input bit with_fs);
    @(negedge clk);
    if (with_fs) begin
      fstart_i = 1'b1; wclk(10); fstart_i = 1'b0; wclk(10);
    end
    for (int i = 0; i < nbits; i++) begin
      logic [15:0] w;
      w = wd(seed, i / 16);
      send_bit(i < 96 ? w[15 - (i % 16)] : 1'b1);
    end
    wclk(20);
  endtask

  task automatic check_words(input int seed, input int at, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      chk(rx_data[at + k] == wd(seed, k), req, int'(rx_data[at + k]), int'(wd(seed, k)));
      chk(rx_chan[at + k] == k, req, rx_chan[at + k], k);
    end
  endtask

  task automatic t_reset;
    chk(!out_valid, "R9 out_valid", int'(out_valid), 0);
    chk(!irq_timeout, "R9 irq", int'(irq_timeout), 0);
    chk({err_short, err_long, err_ovr} == 3'b000, "R9 flags",
        int'({err_short, err_long, err_ovr}), 0);
  endtask

  task automatic t_before_frame;
    out_ready = 1'b1; rx_n = 0;
    send_burst(9, 32, 1'b0);
    chk(rx_n == 0, "R2 bits before first frame start", rx_n, 0);
    chk(!out_valid, "R2 nothing queued", int'(out_valid), 0);
  endtask

  task automatic t_burst(input int seed, input string req);
    out_ready = 1'b1; rx_n = 0;
    send_burst(seed, 96, 1'b1);
    chk(rx_n == 6, req, rx_n, 6);
    check_words(seed, 0, 6, req);
    chk({err_short, err_long, err_ovr} == 3'b000, req, int'({err_short, err_long, err_ovr}), 0);
  endtask

  task automatic t_stall_and_timeout;
    out_ready = 1'b0; rx_n = 0;
    send_burst(3, 96, 1'b1);
    chk(out_valid, "R3 data held while stalled", int'(out_valid), 1);
    chk(err_ovr, "R4 overrun set", int'(err_ovr), 1);
    wclk(230);
    chk(!irq_timeout, "R7 no irq at 25 periods", int'(irq_timeout), 0);
    wclk(150);
    chk(irq_timeout, "R7 irq after 32 periods", int'(irq_timeout), 1);
    out_ready = 1'b1;
    wclk(10);
    chk(rx_n == 4, "R3 FIFO depth 4 kept", rx_n, 4);
    check_words(3, 0, 4, "R3 order after stall");
    chk(!irq_timeout, "R7 irq drops when empty", int'(irq_timeout), 0);
    chk(err_ovr, "R4 overrun sticky", int'(err_ovr), 1);
  endtask

  task automatic t_clear;
    @(negedge clk); clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    wclk(2);
    chk({err_short, err_long, err_ovr} == 3'b000, "R8 clear",
        int'({err_short, err_long, err_ovr}), 0);
  endtask

  task automatic t_short;
    out_ready = 1'b1; rx_n = 0;
    send_burst(4, 40, 1'b1);
    chk(!err_short, "R5 no flag yet", int'(err_short), 0);
    send_burst(5, 96, 1'b1);
    chk(err_short, "R5 short flag", int'(err_short), 1);
    chk(rx_n == 8, "R5 partial word discarded", rx_n, 8);
    check_words(4, 0, 2, "R5 words before cut");
    check_words(5, 2, 6, "R5 next burst realigned");
  endtask

  task automatic t_long;
    out_ready = 1'b1; rx_n = 0;
    send_burst(6, 112, 1'b1);
    chk(err_long, "R6 overlength flag", int'(err_long), 1);
    chk(rx_n == 6, "R6 extra bits ignored", rx_n, 6);
    check_words(6, 0, 6, "R6 words intact");
    chk(!err_short, "R6 no short flag", int'(err_short), 0);
  endtask

  initial begin
    wclk(5);
    t_reset;
    rst_n = 1'b1;
    wclk(5);
    t_before_frame;
    t_burst(1, "R1 burst words and tags");
    t_burst(2, "R2 second burst realigned");
    t_stall_and_timeout;
    t_clear;
    t_short;
    t_clear;
    t_long;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule